// File: doc/BRIEF.md
# Fixed-Frequency Chopping Decay Controller

This block sequences the four gate enables of one H-bridge so that the current in one motor winding is regulated by fixed-period chopping. Every period opens with a drive phase in the polarity that was commanded at the moment the period began. For a programmable blanking interval the current-trip comparator is not looked at, which also fixes the shortest possible on-time. Once a trip is accepted it is held until the period ends, and the bridge sits in one of three decay behaviours: slow, fast, or mixed.

In slow decay both low-side switches conduct so the current recirculates. In fast decay the bridge is driven in reverse, and a zero-cross input turns all switches off so that no reverse current builds up. Mixed decay runs fast decay up to a fixed point late in the period and slow decay after it, but only when the setpoint is falling; on rising steps it behaves as slow decay. Each leg passes through a dead interval with both of its switches off whenever its conducting switch changes. Period, blanking, mixed switch-over point and dead interval are all counted in system clocks and set by parameters.

Top module: `chop_decay_ctrl`

## Requirements
- R1: While reset is active or `bridge_en` is low, all four gate outputs are 0; dropping `bridge_en` clears them in the same cycle.
- R2: Gate outputs are read as {a_hi, a_lo, b_hi, b_lo}. The drive phase gives 1001 when `pol` is 1 and 0110 when `pol` is 0. `pol` is sampled only at the start of each period; changes during a period have no effect.
- R3: During the first BLANK+1 counts of a period (count 0..BLANK), `trip` is ignored. A trip pulse that ends inside this window leaves the bridge in drive for the whole period.
- R4: A trip accepted after blanking is latched. The decay phase lasts until the period ends even if `trip` falls again.
- R5: With `decay_sel` = 00 (slow), the decay pattern is 0101 (both low sides on).
- R6: With `decay_sel` = 10 or 11 (fast), the decay pattern is the drive pattern reversed: 0110 for `pol` = 1, 1001 for `pol` = 0.
- R7: In fast decay, a high `zero_x` switches all four gates off, and they stay off until the period ends (or until the mixed switch-over point of R8).
- R8: With `decay_sel` = 01 (mixed) and `cur_rising` = 0, decay starts fast and turns slow at count MIX_AT. This also happens after a zero-cross. A trip accepted at count MIX_AT-1 or later goes straight to slow.
- R9: With `decay_sel` = 01 and `cur_rising` = 1, the decay is slow.
- R10: A period lasts PERIOD clocks. At its end, any decay phase stops and a new drive phase begins.
- R11: A leg never has both switches on. When a leg's conducting switch changes, both of its switches stay off for exactly DEAD clocks. Gate outputs follow the phase one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_en | input | 1 | Bridge enable; low forces all gates off |
| pol | input | 1 | Commanded current polarity (1: leg A high, leg B low) |
| trip | input | 1 | Current-trip comparator, high when current exceeds the set level |
| zero_x | input | 1 | High when winding current has decayed to near zero |
| decay_sel | input | 2 | 00 slow, 01 mixed, 10/11 fast |
| cur_rising | input | 1 | High when the current setpoint of this step is increasing |
| gate_a_hi | output | 1 | Leg A high-side gate enable |
| gate_a_lo | output | 1 | Leg A low-side gate enable |
| gate_b_hi | output | 1 | Leg B high-side gate enable |
| gate_b_lo | output | 1 | Leg B low-side gate enable |

## Verification
The hardest situation to reach is the mixed-decay switch-over. It only shows when three things line up: a trip is accepted after blanking, the setpoint is falling, and the period runs on to the switch-over count. A zero-cross arriving in between changes the pattern before the switch-over. The stimulus resets the block before each vector, then counts clocks from the enabling edge. This lets it place trip, zero-cross and the sample point at chosen counts of the period. With that, the switch-over can be probed with and without a preceding zero-cross, and for a trip that arrives after the switch-over count.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_DRIVE = 3'd1,
    PH_FAST  = 3'd2,
    PH_SLOW  = 3'd3,
    PH_COAST = 3'd4
  } phase_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_t;

  // index 1 is leg A, index 0 is leg B
  typedef leg_t [1:0] bridge_t;

  localparam leg_t LEG_OFF = 2'b00;
  localparam leg_t LEG_HI  = 2'b10;
  localparam leg_t LEG_LO  = 2'b01;

  localparam logic [1:0] SEL_SLOW  = 2'b00;
  localparam logic [1:0] SEL_MIXED = 2'b01;

  // Gate pattern wanted for a phase and latched polarity.
  function automatic bridge_t gate_pattern(phase_e ph, logic pol);
    bridge_t b;
    case (ph)
      PH_DRIVE: b = pol ? {LEG_HI, LEG_LO} : {LEG_LO, LEG_HI};
      PH_FAST:  b = pol ? {LEG_LO, LEG_HI} : {LEG_HI, LEG_LO};
      PH_SLOW:  b = {LEG_LO, LEG_LO};
      default:  b = {LEG_OFF, LEG_OFF};
    endcase
    return b;
  endfunction

  // Decay phase entered when a trip is accepted.
  function automatic phase_e decay_entry(logic [1:0] sel, logic rising, logic past_mix);
    phase_e ph;
    if (sel == SEL_SLOW)       ph = PH_SLOW;
    else if (sel[1])           ph = PH_FAST;
    else if (rising || past_mix) ph = PH_SLOW;
    else                       ph = PH_FAST;
    return ph;
  endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD = 2500,
  parameter int BLANK  = 469,
  parameter int MIX_AT = 1875
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  output logic [$clog2(PERIOD)-1:0]   cnt_o,
  output logic                        last_o,
  output logic                        blank_done_o,
  output logic                        mix_point_o,
  output logic                        mix_late_o
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST_C  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK);
  localparam logic [CW-1:0] MIXM1_C = CW'(MIX_AT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)       cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o        = cnt_q;
  assign last_o       = run && (cnt_q == LAST_C);
  assign blank_done_o = cnt_q >= BLANK_C;
  assign mix_point_o  = cnt_q == MIXM1_C;
  assign mix_late_o   = cnt_q >= MIXM1_C;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C); // R10

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridge_en,
  input  logic       pol,
  input  logic       trip,
  input  logic       zero_x,
  input  logic [1:0] decay_sel,
  input  logic       cur_rising,
  input  logic       cyc_last,
  input  logic       blank_done,
  input  logic       mix_point,
  input  logic       mix_late,
  output phase_e     phase_o,
  output logic       pol_o,
  output logic       trip_lat_o
);
  phase_e phase_q, phase_d;
  logic   pol_q, pol_d;
  logic   lat_q, lat_d;
  logic   arm_q, arm_d;
  logic   trip_seen;
  logic   mixed_dec;

  assign trip_seen = trip && blank_done;
  assign mixed_dec = (decay_sel == SEL_MIXED) && !cur_rising;

  always_comb begin
    phase_d = phase_q;
    pol_d   = pol_q;
    lat_d   = lat_q;
    arm_d   = arm_q;
    if (!bridge_en) begin
      phase_d = PH_OFF;
      lat_d   = 1'b0;
      arm_d   = 1'b0;
    end else if (phase_q == PH_OFF || cyc_last) begin
      phase_d = PH_DRIVE;
      pol_d   = pol;
      lat_d   = 1'b0;
      arm_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_DRIVE: if (trip_seen) begin
          lat_d   = 1'b1;
          arm_d   = mixed_dec;
          phase_d = decay_entry(decay_sel, cur_rising, mix_late);
        end
        PH_FAST: begin
          if (arm_q && mix_point) phase_d = PH_SLOW;
          else if (zero_x)        phase_d = PH_COAST;
        end
        PH_COAST: if (arm_q && mix_point) phase_d = PH_SLOW;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      pol_q   <= 1'b0;
      lat_q   <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pol_q   <= pol_d;
      lat_q   <= lat_d;
      arm_q   <= arm_d;
    end
  end

  assign phase_o    = phase_q;
  assign pol_o      = pol_q;
  assign trip_lat_o = lat_q;

  AST_TRIP_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && bridge_en && !cyc_last) |=> lat_q); // R4
  AST_DECAY_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FAST || phase_q == PH_SLOW || phase_q == PH_COAST) |-> lat_q); // R4
  AST_COAST_AFTER_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COAST) |-> ($past(phase_q) == PH_FAST || $past(phase_q) == PH_COAST)); // R7

endmodule

// File: rtl/chop_leg_deadtime.sv
module chop_leg_deadtime
  import chop_pkg::*;
#(
  parameter int DEAD = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  leg_t want,
  output leg_t q_o
);
  localparam int DW = $clog2(DEAD + 1);
  localparam logic [DW-1:0] DEAD_C = DW'(DEAD);

  leg_t          q;
  logic [DW-1:0] dt_q;
  logic [DW-1:0] dt_inc;

  assign dt_inc = (dt_q >= DEAD_C) ? DEAD_C : dt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= LEG_OFF;
      dt_q <= DEAD_C;
    end else if (clear || (want != q && q != LEG_OFF)) begin
      q    <= LEG_OFF;
      dt_q <= (q != LEG_OFF) ? DW'(1) : dt_inc;
    end else if (want == q) begin
      dt_q <= dt_inc;
    end else if (dt_q >= DEAD_C) begin
      q <= want;
    end else begin
      dt_q <= dt_inc;
    end
  end

  assign q_o = q;

  logic hs_w, ls_w;
  assign hs_w = q.hs;
  assign ls_w = q.ls;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_w && ls_w)); // R11
  AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_w) |-> !$past(ls_w)); // R11
  AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_w) |-> !$past(hs_w)); // R11

endmodule

// File: rtl/chop_decay_ctrl.sv
module chop_decay_ctrl
  import chop_pkg::*;
#(
  parameter int PERIOD = 2500,
  parameter int BLANK  = 469,
  parameter int MIX_AT = 1875,
  parameter int DEAD   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridge_en,
  input  logic       pol,
  input  logic       trip,
  input  logic       zero_x,
  input  logic [1:0] decay_sel,
  input  logic       cur_rising,
  output logic       gate_a_hi,
  output logic       gate_a_lo,
  output logic       gate_b_hi,
  output logic       gate_b_lo
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK);

  phase_e        phase_q;
  logic          pol_q;
  logic          trip_lat_q;
  logic [CW-1:0] cnt_q;
  logic          cyc_last;
  logic          blank_done;
  logic          mix_point;
  logic          mix_late;
  logic          run;
  bridge_t       want;
  bridge_t       legs;

  assign run = (phase_q != PH_OFF);

  chop_period_timer #(.PERIOD(PERIOD), .BLANK(BLANK), .MIX_AT(MIX_AT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cnt_o(cnt_q), .last_o(cyc_last), .blank_done_o(blank_done),
    .mix_point_o(mix_point), .mix_late_o(mix_late)
  );

  chop_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .pol(pol),
    .trip(trip), .zero_x(zero_x), .decay_sel(decay_sel), .cur_rising(cur_rising),
    .cyc_last(cyc_last), .blank_done(blank_done), .mix_point(mix_point),
    .mix_late(mix_late), .phase_o(phase_q), .pol_o(pol_q), .trip_lat_o(trip_lat_q)
  );

  assign want = gate_pattern(phase_q, pol_q);

  for (genvar g = 0; g < 2; g++) begin : g_leg
    chop_leg_deadtime #(.DEAD(DEAD)) u_leg (
      .clk(clk), .rst_n(rst_n), .clear(~bridge_en),
      .want(want[g]), .q_o(legs[g])
    );
  end

  assign gate_a_hi = legs[1].hs & bridge_en;
  assign gate_a_lo = legs[1].ls & bridge_en;
  assign gate_b_hi = legs[0].hs & bridge_en;
  assign gate_b_lo = legs[0].ls & bridge_en;

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q <= BLANK_C) |-> (phase_q == PH_DRIVE)); // R3
  AST_CYCLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_en && cyc_last) |=> (phase_q == PH_DRIVE && cnt_q == '0)); // R10
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |=> (phase_q == PH_OFF && !trip_lat_q)); // R1

endmodule

// File: tb/tb_chop_decay_ctrl.sv
`timescale 1ns/1ps
module tb_chop_decay_ctrl;
  localparam int PERIOD = 40;
  localparam int BLANK  = 6;
  localparam int MIX_AT = 30;
  localparam int DEAD   = 2;
  localparam logic [7:0] NONE = 8'd255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridge_en = 1'b0;
  logic pol = 1'b1;
  logic trip = 1'b0;
  logic zero_x = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic cur_rising = 1'b0;
  logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chop_decay_ctrl #(.PERIOD(PERIOD), .BLANK(BLANK), .MIX_AT(MIX_AT), .DEAD(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .pol(pol), .trip(trip),
    .zero_x(zero_x), .decay_sel(decay_sel), .cur_rising(cur_rising),
    .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo), .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic       rise;
    logic       pol;
    logic [7:0] t_trip;
    logic [7:0] t_len;
    logic [7:0] t_zx;
    logic [7:0] probe;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  // count k = clocks since the enabling edge; gates read {a_hi,a_lo,b_hi,b_lo}
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b1, NONE,  8'd0,  NONE,  8'd5,  4'b1001, 4'd2},  // R2
    '{2'd0, 1'b0, 1'b0, NONE,  8'd0,  NONE,  8'd5,  4'b0110, 4'd2},  // R2
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd11, 4'b1001, 4'd11}, // R11 one-clock lag
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd12, 4'b0001, 4'd11}, // R11 dead gap
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd14, 4'b0101, 4'd5},  // R5
    '{2'd2, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd12, 4'b0000, 4'd11}, // R11
    '{2'd2, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd20, 4'b0110, 4'd6},  // R6
    '{2'd2, 1'b0, 1'b0, 8'd10, 8'd99, NONE,  8'd20, 4'b1001, 4'd6},  // R6
    '{2'd3, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd20, 4'b0110, 4'd6},  // R6
    '{2'd0, 1'b0, 1'b1, 8'd2,  8'd99, NONE,  8'd7,  4'b1001, 4'd3},  // R3
    '{2'd0, 1'b0, 1'b1, 8'd2,  8'd99, NONE,  8'd8,  4'b0001, 4'd3},  // R3
    '{2'd0, 1'b0, 1'b1, 8'd2,  8'd3,  NONE,  8'd20, 4'b1001, 4'd3},  // R3 pulse in blanking
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd1,  NONE,  8'd20, 4'b0101, 4'd4},  // R4
    '{2'd1, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd29, 4'b0110, 4'd8},  // R8
    '{2'd1, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd31, 4'b0100, 4'd8},  // R8
    '{2'd1, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd33, 4'b0101, 4'd8},  // R8
    '{2'd1, 1'b1, 1'b1, 8'd10, 8'd99, NONE,  8'd20, 4'b0101, 4'd9},  // R9
    '{2'd2, 1'b0, 1'b1, 8'd10, 8'd99, 8'd20, 8'd21, 4'b0110, 4'd7},  // R7
    '{2'd2, 1'b0, 1'b1, 8'd10, 8'd99, 8'd20, 8'd25, 4'b0000, 4'd7},  // R7
    '{2'd1, 1'b0, 1'b1, 8'd10, 8'd99, 8'd20, 8'd31, 4'b0101, 4'd8},  // R8 after zero-cross
    '{2'd1, 1'b0, 1'b1, 8'd33, 8'd99, NONE,  8'd37, 4'b0101, 4'd8},  // R8 late trip
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd40, 4'b0101, 4'd10}, // R10
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd41, 4'b0001, 4'd10}, // R10
    '{2'd0, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd43, 4'b1001, 4'd10}, // R10
    '{2'd2, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd41, 4'b0000, 4'd10}, // R10
    '{2'd2, 1'b0, 1'b1, 8'd10, 8'd99, NONE,  8'd43, 4'b1001, 4'd10}  // R10
  };

  function automatic logic [3:0] gates();
    return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
  endfunction

  task automatic check(string req, logic [3:0] exp, string what);
    n_vec++;
    if (gates() !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, gates(), exp);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0; bridge_en = 1'b0; trip = 1'b0; zero_x = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(vec_t v);
    int t, l, z, p;
    t = int'(v.t_trip); l = int'(v.t_len); z = int'(v.t_zx); p = int'(v.probe);
    restart();
    decay_sel = v.sel; cur_rising = v.rise; pol = v.pol;
    bridge_en = 1'b1;
    for (int k = 0; k <= p; k++) begin
      @(negedge clk);
      if (k == p) check($sformatf("R%0d", v.req), v.exp, $sformatf("probe at count %0d", k));
      trip   = (k >= t) && (k < t + l) && (k < PERIOD);
      zero_x = (k >= z) && (k < PERIOD);
    end
    trip = 1'b0; zero_x = 1'b0;
  endtask

  initial begin
    // R1: reset state, even with the bridge enabled
    bridge_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 4'b0000, "during reset");
    bridge_en = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: disabling mid-drive clears the gates at once and keeps them off
    restart();
    pol = 1'b1; decay_sel = 2'b00;
    bridge_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R2", 4'b1001, "drive before disable");
    bridge_en = 1'b0;
    #1 check("R1", 4'b0000, "same cycle as disable");
    repeat (4) @(negedge clk);
    check("R1", 4'b0000, "held disabled");
    bridge_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10", 4'b1001, "drive one clock after re-enable");

    // R2: polarity change inside a period is ignored until the next period
    restart();
    pol = 1'b1; decay_sel = 2'b00;
    bridge_en = 1'b1;
    repeat (4) @(negedge clk);
    pol = 1'b0;
    repeat (6) @(negedge clk);
    check("R2", 4'b1001, "pol flipped mid-period");
    // new period starts at count 40 with pol 0: both legs swap, off 41..42, 0110 at 43
    repeat (34) @(negedge clk);
    check("R2", 4'b0110, "pol taken at next period");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule